// File: doc/BRIEF.md
# Channel-Status and User-Bit Block Capture

This block sits behind a digital audio receiver's subframe decoder. For each decoded subframe it takes the channel index, the channel-status bit, the user bit and a flag that marks the first frame of a 192-frame block. It then gathers a complete 192-bit channel-status record and a complete 192-bit user record for each of the two channels. Bit k of a record is the bit received in frame k of the block. The records are held in a shadow buffer while they fill. Only when both channels have delivered all 192 frames is the whole set copied to the readable registers in one cycle, so software never reads a half-filled block.

At that copy the block raises a block-end event. It also compares each channel's new channel-status record with the copy it replaces and raises a per-channel change event when they differ. A separate event marks every start of block. Events land in a status register that is cleared when read, and an interrupt mask is set and cleared through separate write addresses. The interrupt output is asserted while any event is both pending and enabled.

Top module: `csu_capture`

## Requirements
- R1: After reset the status register, the mask register, every record word and the interrupt output are all zero.
- R2: A complete block is one started by a start-flagged channel-0 subframe, followed by 192 bits on each channel. Record bit k (frame k) appears in word k/32, at bit position k%32. That puts byte 0 in bits 7:0 of word 0 and bit 0 of each byte at the byte's LSB. Channel-status words for channel c are read at 0x30 + c*0x30 + 4*w, and user words at 0x48 + c*0x30 + 4*w, for w = 0..5.
- R3: Record words keep the previous complete block's values until the next block completes, including while a block is being filled.
- R4: Status bit 3 (block end) is set when both channels have received all 192 bits of a block.
- R5: Status bit 11 (block start) is set by a start-flagged subframe on channel 0. A start flag on a channel-1 subframe has no effect.
- R6: At block end, status bit 8+c is set exactly when channel c's new channel-status record differs from the stored one. Differences in user bits set no change bit.
- R7: A block interrupted by a new start flag before it completes is discarded. It updates no record word and sets neither bit 3 nor any change bit.
- R8: Subframes are ignored when no block is open, that is before the first start flag and after a block completes until the next start flag.
- R9: Writing 0x10 sets the mask bits that are one in the written data, writing 0x14 clears them, and the mask reads back at 0x18. Only bits 3, 8, 9 and 11 exist; all other mask bits read as zero.
- R10: Reading the status register at 0x1C returns its value and clears it. The interrupt output is high exactly while some status bit is set and its mask bit is set.
- R11: Read data appears on the cycle after the address is presented. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfValid | input | 1 | One-cycle strobe per decoded subframe |
| sfChan | input | 1 | Channel index of the subframe |
| sfC | input | 1 | Channel-status bit of the subframe |
| sfU | input | 1 | User bit of the subframe |
| sfStart | input | 1 | Subframe belongs to frame 0 of a block |
| regAddr | input | 8 | Register byte address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears status on 0x1C) |
| regWData | input | 16 | Register write data |
| regRData | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench interrupts a block after 100 frames and then sends a full block with unchanged channel status. A design that committed the partial block would show new record words, or would raise a change bit on the following block. It re-sends an identical channel-status record with fresh user bits, which catches a change detector that compares user data or always fires. It also sends a full block's worth of subframes with no start flag after a completed block, which exposes a capture that wraps around instead of closing. Single-bit directed records (bit 0, bit 32, bit 191) pin the byte and word placement, where a reversed or swapped order would put the set bit in the wrong word or position.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int POS_W = 8;
  localparam int CH_IDX_W = 1;
  localparam int IRQ_W = 16;

  localparam int BLKEND_BIT = 3;
  localparam int CSC_BIT0 = 8;
  localparam int BLKST_BIT = 11;

  localparam int OFF_IEN = 'h10;
  localparam int OFF_IDIS = 'h14;
  localparam int OFF_IMASK = 'h18;
  localparam int OFF_ISTAT = 'h1C;
  localparam int CS_BASE = 'h30;
  localparam int CH_STRIDE = 'h30;
  localparam int UD_OFS = 'h18;

  typedef struct packed {
    logic wrEn;
    logic [CH_IDX_W-1:0] chan;
    logic [POS_W-1:0] bitPos;
    logic bitC;
    logic bitU;
    logic commit;
  } capStrobe_t;

  function automatic logic [IRQ_W-1:0] irqValid(input int nCh);
    logic [IRQ_W-1:0] m;
    m = '0;
    m[BLKEND_BIT] = 1'b1;
    m[BLKST_BIT] = 1'b1;
    for (int c = 0; c < nCh; c++) m[CSC_BIT0 + c] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/csu_ctrl.sv
module csu_ctrl
  import csu_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int BLOCK_BITS = 192,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sfValid,
  input  logic [CH_IDX_W-1:0] sfChan,
  input  logic sfC,
  input  logic sfU,
  input  logic sfStart,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic regWr,
  input  logic regRd,
  input  logic [IRQ_W-1:0] regWData,
  input  logic [NUM_CH-1:0] csDiff,
  output capStrobe_t st,
  output logic [IRQ_W-1:0] isr,
  output logic [IRQ_W-1:0] imr
);
  localparam int CNT_W = $clog2(BLOCK_BITS + 1);
  localparam logic [IRQ_W-1:0] VALID = irqValid(NUM_CH);

  logic [CNT_W-1:0] cnt [NUM_CH];
  logic active;
  logic commitPend;
  logic startHit;
  logic othersDone;
  logic lastWrite;
  logic [IRQ_W-1:0] evtSet;

  always_comb begin
    startHit = sfValid && sfStart && (sfChan == '0);
    othersDone = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (CH_IDX_W'(c) != sfChan && cnt[c] != CNT_W'(BLOCK_BITS)) othersDone = 1'b0;
    end
    st = '0;
    st.chan = sfChan;
    st.bitC = sfC;
    st.bitU = sfU;
    st.commit = commitPend;
    if (startHit) begin
      st.wrEn = 1'b1;
      st.bitPos = '0;
    end else if (sfValid && active && cnt[sfChan] < CNT_W'(BLOCK_BITS)) begin
      st.wrEn = 1'b1;
      st.bitPos = POS_W'(cnt[sfChan]);
    end
    lastWrite = st.wrEn && !startHit && othersDone &&
                (st.bitPos == POS_W'(BLOCK_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) cnt[c] <= '0;
      active <= 1'b0;
      commitPend <= 1'b0;
    end else begin
      commitPend <= lastWrite;
      if (startHit) begin
        for (int c = 0; c < NUM_CH; c++) cnt[c] <= (c == 0) ? CNT_W'(1) : '0;
        active <= 1'b1;
      end else if (st.wrEn) begin
        cnt[sfChan] <= cnt[sfChan] + CNT_W'(1);
        if (lastWrite) active <= 1'b0;
      end
    end
  end

  always_comb begin
    evtSet = '0;
    if (startHit) evtSet[BLKST_BIT] = 1'b1;
    if (commitPend) begin
      evtSet[BLKEND_BIT] = 1'b1;
      for (int c = 0; c < NUM_CH; c++) evtSet[CSC_BIT0 + c] = csDiff[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isr <= '0;
      imr <= '0;
    end else begin
      if (regRd && regAddr == ADDR_W'(OFF_ISTAT)) isr <= evtSet;
      else isr <= isr | evtSet;
      if (regWr && regAddr == ADDR_W'(OFF_IEN)) imr <= imr | (regWData & VALID);
      else if (regWr && regAddr == ADDR_W'(OFF_IDIS)) imr <= imr & ~regWData;
    end
  end
endmodule

// File: rtl/csu_store.sv
module csu_store
  import csu_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int BLOCK_BITS = 192,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  capStrobe_t st,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [NUM_CH-1:0] csDiff,
  output logic dataHit,
  output logic [WORD_W-1:0] dataWord
);
  localparam int WORDS = BLOCK_BITS / WORD_W;

  logic [BLOCK_BITS-1:0] shC [NUM_CH];
  logic [BLOCK_BITS-1:0] shU [NUM_CH];
  logic [BLOCK_BITS-1:0] vC [NUM_CH];
  logic [BLOCK_BITS-1:0] vU [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shC[g] <= '0;
        shU[g] <= '0;
        vC[g] <= '0;
        vU[g] <= '0;
      end else begin
        if (st.wrEn && st.chan == CH_IDX_W'(g)) begin
          shC[g][st.bitPos] <= st.bitC;
          shU[g][st.bitPos] <= st.bitU;
        end
        if (st.commit) begin
          vC[g] <= shC[g];
          vU[g] <= shU[g];
        end
      end
    end
    assign csDiff[g] = (shC[g] != vC[g]);
  end

  always_comb begin
    dataHit = 1'b0;
    dataWord = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (regAddr == ADDR_W'(CS_BASE + c * CH_STRIDE + 4 * w)) begin
          dataHit = 1'b1;
          dataWord = vC[c][w*WORD_W +: WORD_W];
        end
        if (regAddr == ADDR_W'(CS_BASE + UD_OFS + c * CH_STRIDE + 4 * w)) begin
          dataHit = 1'b1;
          dataWord = vU[c][w*WORD_W +: WORD_W];
        end
      end
    end
  end
endmodule

// File: rtl/csu_capture.sv
module csu_capture
  import csu_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int BLOCK_BITS = 192,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sfValid,
  input  logic [CH_IDX_W-1:0] sfChan,
  input  logic sfC,
  input  logic sfU,
  input  logic sfStart,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic regWr,
  input  logic regRd,
  input  logic [IRQ_W-1:0] regWData,
  output logic [WORD_W-1:0] regRData,
  output logic irq
);
  capStrobe_t st;
  logic [NUM_CH-1:0] csDiff;
  logic [IRQ_W-1:0] isrQ;
  logic [IRQ_W-1:0] imrQ;
  logic dataHit;
  logic [WORD_W-1:0] dataWord;
  logic [WORD_W-1:0] ctlWord;

  csu_ctrl #(.NUM_CH(NUM_CH), .BLOCK_BITS(BLOCK_BITS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sfValid(sfValid), .sfChan(sfChan), .sfC(sfC),
    .sfU(sfU), .sfStart(sfStart), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWData(regWData), .csDiff(csDiff), .st(st),
    .isr(isrQ), .imr(imrQ)
  );

  csu_store #(.NUM_CH(NUM_CH), .BLOCK_BITS(BLOCK_BITS), .WORD_W(WORD_W),
              .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rstN(rstN), .st(st), .regAddr(regAddr), .csDiff(csDiff),
    .dataHit(dataHit), .dataWord(dataWord)
  );

  always_comb begin
    ctlWord = '0;
    if (regAddr == ADDR_W'(OFF_IMASK)) ctlWord = WORD_W'(imrQ);
    else if (regAddr == ADDR_W'(OFF_ISTAT)) ctlWord = WORD_W'(isrQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRData <= '0;
    else regRData <= dataHit ? dataWord : ctlWord;
  end

  assign irq = |(isrQ & imrQ);
endmodule

// File: rtl/csu_chk.sv
module csu_chk
  import csu_pkg::*;
#(
  parameter int BLOCK_BITS = 192
) (
  input logic clk,
  input logic rstN,
  input logic sfValid,
  input logic [CH_IDX_W-1:0] sfChan,
  input logic sfStart,
  input logic regWr,
  input capStrobe_t st,
  input logic [IRQ_W-1:0] isr,
  input logic [IRQ_W-1:0] imr
);
  // R4
  blkend_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> isr[BLKEND_BIT]);
  // R6
  csc0_only_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isr[CSC_BIT0]) |-> $past(st.commit));
  // R6
  csc1_only_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isr[CSC_BIT0 + 1]) |-> $past(st.commit));
  // R5
  blkst_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isr[BLKST_BIT]) |-> $past(sfValid && sfStart && sfChan == '0));
  // R9
  mask_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(imr) |-> $past(regWr));
  // R8
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |-> st.bitPos < POS_W'(BLOCK_BITS));
endmodule

bind csu_capture csu_chk #(.BLOCK_BITS(BLOCK_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .sfValid(sfValid), .sfChan(sfChan),
  .sfStart(sfStart), .regWr(regWr), .st(st), .isr(isrQ), .imr(imrQ)
);

// File: tb/sim_csu_capture.sv
`timescale 1ns/1ps
module sim_csu_capture;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sfValid = 1'b0;
  logic [0:0] sfChan = '0;
  logic sfC = 1'b0;
  logic sfU = 1'b0;
  logic sfStart = 1'b0;
  logic [7:0] regAddr = '0;
  logic regWr = 1'b0;
  logic regRd = 1'b0;
  logic [15:0] regWData = '0;
  logic [31:0] regRData;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [191:0] mC [2];
  logic [191:0] mU [2];

  always #2.5 clk = ~clk;

  csu_capture u0 (
    .clk(clk), .rstN(rstN), .sfValid(sfValid), .sfChan(sfChan), .sfC(sfC),
    .sfU(sfU), .sfStart(sfStart), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWData(regWData), .regRData(regRData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [191:0] rnd192();
    logic [191:0] v;
    for (int i = 0; i < 6; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] expEnd(input logic [191:0] c0, input logic [191:0] c1);
    logic [31:0] e;
    e = 32'h0808;
    if (c0 != mC[0]) e[8] = 1'b1;
    if (c1 != mC[1]) e[9] = 1'b1;
    return e;
  endfunction

  task automatic sub(input bit ch, input bit c, input bit u, input bit s);
    @(negedge clk);
    sfValid = 1'b1; sfChan = ch; sfC = c; sfU = u; sfStart = s;
    @(negedge clk);
    sfValid = 1'b0; sfStart = 1'b0;
  endtask

  task automatic sendBlock(input logic [191:0] c0, input logic [191:0] c1,
                           input logic [191:0] u0, input logic [191:0] u1,
                           input int nFrames, input bit withStart);
    for (int f = 0; f < nFrames; f++) begin
      sub(1'b0, c0[f % 192], u0[f % 192], withStart && f == 0);
      sub(1'b1, c1[f % 192], u1[f % 192], 1'b0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] d;
    for (int c = 0; c < 2; c++) begin
      for (int w = 0; w < 6; w++) begin
        rd(8'(8'h30 + c * 8'h30 + 4 * w), d);
        chk(req, d, mC[c][w*32 +: 32]);
        rd(8'(8'h48 + c * 8'h30 + 4 * w), d);
        chk(req, d, mU[c][w*32 +: 32]);
      end
    end
  endtask

  task automatic fullBlock(input string req, input logic [191:0] c0, input logic [191:0] c1,
                           input logic [191:0] u0, input logic [191:0] u1);
    logic [31:0] d;
    logic [31:0] e;
    e = expEnd(c0, c1);
    sendBlock(c0, c1, u0, u1, 192, 1'b1);
    rd(8'h1C, d);
    chk(req, d, e);
    mC[0] = c0; mC[1] = c1; mU[0] = u0; mU[1] = u1;
    checkAll(req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [191:0] a0, a1, b0, b1, t0, t1;
    void'($urandom(32'd4242));
    for (int c = 0; c < 2; c++) begin mC[c] = '0; mU[c] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    rd(8'h1C, d); chk("R1 isr", d, 32'h0);
    rd(8'h18, d); chk("R1 imr", d, 32'h0);
    checkAll("R1 words");

    // R11 unmapped
    rd(8'h04, d); chk("R11 unmapped 04", d, 32'h0);
    rd(8'h2C, d); chk("R11 unmapped 2C", d, 32'h0);

    // R9 mask set/clear
    wr(8'h10, 16'hFFFF); rd(8'h18, d); chk("R9 ien", d, 32'h0B08);
    wr(8'h14, 16'h0800); rd(8'h18, d); chk("R9 idis", d, 32'h0308);
    wr(8'h10, 16'h0800); rd(8'h18, d); chk("R9 ien again", d, 32'h0B08);

    // R5 start flag on channel 1 ignored
    sub(1'b1, 1'b1, 1'b1, 1'b1);
    rd(8'h1C, d); chk("R5 ch1 start ignored", d, 32'h0);

    // R8 stray subframes before any start
    sendBlock(rnd192(), rnd192(), rnd192(), rnd192(), 192, 1'b0);
    rd(8'h1C, d); chk("R8 no open block", d, 32'h0);
    checkAll("R8 words");

    // R2 R4 R6 random block; R10 irq and read-clear
    a0 = rnd192(); a1 = rnd192();
    sendBlock(a0, a1, rnd192(), rnd192(), 0, 1'b1);
    begin
      logic [191:0] ua0, ua1;
      logic [31:0] e;
      ua0 = rnd192(); ua1 = rnd192();
      e = expEnd(a0, a1);
      sendBlock(a0, a1, ua0, ua1, 192, 1'b1);
      chk("R10 irq pending", 32'(irq), 32'h1);
      rd(8'h1C, d); chk("R4 R6 isr block A", d, e);
      rd(8'h1C, d); chk("R10 isr cleared", d, 32'h0);
      chk("R10 irq low after clear", 32'(irq), 32'h0);
      mC[0] = a0; mC[1] = a1; mU[0] = ua0; mU[1] = ua1;
      checkAll("R2 block A");
    end

    // R6 same channel status, new user bits
    fullBlock("R6 same cs", a0, a1, rnd192(), rnd192());
    // R6 only channel 1 changes
    b1 = rnd192();
    fullBlock("R6 ch1 change", a0, b1, rnd192(), rnd192());

    // R7 R3 truncated block
    t0 = rnd192(); t1 = rnd192();
    sendBlock(t0, t1, rnd192(), rnd192(), 100, 1'b1);
    rd(8'h1C, d); chk("R7 only start", d, 32'h0800);
    checkAll("R3 words held");
    fullBlock("R7 no csc after discard", a0, b1, rnd192(), rnd192());

    // R8 after completion, no start
    sendBlock(rnd192(), rnd192(), rnd192(), rnd192(), 192, 1'b0);
    rd(8'h1C, d); chk("R8 closed after end", d, 32'h0);
    checkAll("R8 words unchanged");

    // R2 directed placement
    b0 = '0; b0[0] = 1'b1;
    b1 = '0; b1[191] = 1'b1;
    t0 = '0; t0[32] = 1'b1;
    t1 = '0; t1[8] = 1'b1;
    fullBlock("R2 directed", b0, b1, t0, t1);
    rd(8'h30, d); chk("R2 cs0 word0 bit0", d, 32'h0000_0001);
    rd(8'h74, d); chk("R2 cs1 word5 bit191", d, 32'h8000_0000);
    rd(8'h4C, d); chk("R2 ud0 word1 bit32", d, 32'h0000_0001);
    rd(8'h78, d); chk("R2 ud1 word0 bit8", d, 32'h0000_0100);

    // R10 mask gating of irq
    sendBlock(b0, b1, t0, t1, 192, 1'b1);
    wr(8'h14, 16'hFFFF);
    chk("R10 irq masked", 32'(irq), 32'h0);
    wr(8'h10, 16'h0008);
    chk("R10 irq unmasked", 32'(irq), 32'h1);
    rd(8'h1C, d); chk("R10 isr value", d, 32'h0808);
    chk("R10 irq after read", 32'(irq), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule